// File: doc/BRIEF.md
# Sprite Page Copy DMA Engine

This block moves one 256-byte page from the CPU address space into a private 256-entry sprite attribute memory. Software starts it by writing a page number to a trigger strobe. The engine works out the source address of every byte from that page number. It issues the reads on a shared memory port and writes each returned byte into the sprite memory in ascending index order.

The top three bits of the page number pick the source region. Region 0 is the internal work RAM, which repeats every 2 KB, so only the low three page bits survive. Region 3 is the battery-backed RAM. Regions 4 to 7 are four 8 KB program banks. Regions 1 and 2 hold no copyable memory, and a trigger that names them does nothing. While the copy runs, `busy` is high so that the CPU can be stalled. A single-cycle `done` pulse marks the end of the copy. Another bus master can hold off the reads through a grant input.

Top module: `spr_page_dma`

## Requirements
- R1: A trigger write (`trig_wr` high for one cycle, `busy` low) whose page number has bits [7:5] equal to 0, 3, 4, 5, 6 or 7 starts a copy of exactly 256 bytes. `busy` is high from the next cycle until the cycle of the last sprite write, inclusive.
- R2: For page p and byte i (0..255), the source address is ((p*256) AND 0x07FF) + i when p[7:5] = 0. Otherwise it is p[7:5]*0x2000 + ((p*256) AND 0x1FFF) + i.
- R3: Byte i is written to sprite index i, in order from 0 to 255. The write data is the value on `mem_rd_data` in the cycle after that byte's read was accepted.
- R4: Each byte takes a read cycle (`mem_rd_en` high) followed by a write cycle (`spr_we` high). The read is accepted in a cycle where `bus_grant` is high. While the grant is low, the read request and its address stay unchanged. The write comes in the cycle after the read is accepted.
- R5: A trigger whose page has bits [7:5] equal to 1 or 2 is ignored: `busy` stays low, no read is issued and no `done` pulse occurs.
- R6: A trigger write that arrives while `busy` is high is ignored. The copy in progress keeps its original page.
- R7: `done` is high for exactly one cycle: the cycle after the final sprite write. `busy` is low in that cycle.
- R8: While reset is asserted and right after it is released, `busy`, `done`, `mem_rd_en` and `spr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_wr | input | 1 | Trigger register write strobe |
| trig_page | input | 8 | Page number written with the trigger |
| bus_grant | input | 1 | Memory port granted this cycle |
| mem_rd_en | output | 1 | Read request on the memory port |
| mem_rd_addr | output | 16 | Source address of the read |
| mem_rd_data | input | 8 | Read data, valid the cycle after an accepted read |
| spr_we | output | 1 | Sprite memory write enable |
| spr_addr | output | 8 | Sprite memory index |
| spr_wdata | output | 8 | Sprite memory write data |
| busy | output | 1 | Copy in progress, CPU should stall |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The hardest situation to reach from the ports is a copy whose reads are held off by the grant at arbitrary points, while a second trigger arrives mid-copy. The grant stalls shift every later write, and the second trigger must not disturb the latched page. The bench sweeps all 256 page numbers, which covers every region, every fold and both ignored regions. On selected pages it drives a cyclic grant-denial pattern and pulses a competing trigger about halfway through the copy. Every accepted address and every sprite entry is compared with values computed from the region arithmetic.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
  localparam int unsigned SEL_BITS = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_t;

  // Regions 1 and 2 carry nothing copyable
  function automatic logic region_copyable(input logic [SEL_BITS-1:0] sel);
    return (sel != 3'd1) && (sel != 3'd2);
  endfunction
endpackage

// File: rtl/spr_src_map.sv
module spr_src_map #(
  parameter int unsigned PAGE_W     = 8,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned RAM_FOLD_W = 11,
  parameter int unsigned BANK_W     = 13
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] src_addr
);
  import spr_dma_pkg::*;

  localparam int unsigned SPAN_W = PAGE_W + IDX_W;
  localparam logic [ADDR_W-1:0] RAM_MASK  = ADDR_W'((1 << RAM_FOLD_W) - 1);
  localparam logic [ADDR_W-1:0] BANK_MASK = ADDR_W'((1 << BANK_W) - 1);

  logic [SEL_BITS-1:0] sel;
  logic [ADDR_W-1:0]   linear;
  logic [ADDR_W-1:0]   region_base;

  assign sel    = page[PAGE_W-1 -: SEL_BITS];
  assign linear = ADDR_W'({page, idx});

  generate
    if (SPAN_W > BANK_W) begin : g_base
      assign region_base = ADDR_W'(sel) << BANK_W;
    end else begin : g_nobase
      assign region_base = '0;
    end
  endgenerate

  always_comb begin
    if (sel == '0) begin
      src_addr = linear & RAM_MASK;
    end else begin
      src_addr = region_base | (linear & BANK_MASK);
    end
  end
endmodule

// File: rtl/spr_byte_seq.sv
module spr_byte_seq #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             grant,
  output logic             rd_en,
  output logic             wr_en,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done
);
  import spr_dma_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_READ;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      SEQ_READ: begin
        if (grant) state_d = SEQ_WRITE;
      end
      SEQ_WRITE: begin
        if (idx_q == LAST_IDX) begin
          state_d = SEQ_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = SEQ_READ;
          idx_d   = idx_q + 1'b1;
          idx_en  = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign rd_en = (state_q == SEQ_READ);
  assign wr_en = (state_q == SEQ_WRITE);
  assign busy  = (state_q != SEQ_IDLE);
  assign done  = done_q;
  assign idx   = idx_q;

  // R4
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && grant |=> wr_en);

  // R1
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (idx != LAST_IDX) |=> rd_en && (idx == $past(idx) + 1'b1));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(wr_en) && ($past(idx) == LAST_IDX));
endmodule

// File: rtl/spr_page_dma.sv
module spr_page_dma #(
  parameter int unsigned PAGE_W     = 8,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RAM_FOLD_W = 11,
  parameter int unsigned BANK_W     = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_wr,
  input  logic [PAGE_W-1:0] trig_page,
  input  logic              bus_grant,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              spr_we,
  output logic [IDX_W-1:0]  spr_addr,
  output logic [DATA_W-1:0] spr_wdata,
  output logic              busy,
  output logic              done
);
  import spr_dma_pkg::*;

  logic [PAGE_W-1:0] page_q;
  logic              start;
  logic [IDX_W-1:0]  idx;

  assign start = trig_wr && !busy &&
                 region_copyable(trig_page[PAGE_W-1 -: SEL_BITS]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (start) begin
      page_q <= trig_page;
    end
  end

  spr_byte_seq #(.IDX_W(IDX_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .grant (bus_grant),
    .rd_en (mem_rd_en),
    .wr_en (spr_we),
    .idx   (idx),
    .busy  (busy),
    .done  (done)
  );

  spr_src_map #(
    .PAGE_W     (PAGE_W),
    .IDX_W      (IDX_W),
    .ADDR_W     (ADDR_W),
    .RAM_FOLD_W (RAM_FOLD_W),
    .BANK_W     (BANK_W)
  ) u_map (
    .page     (page_q),
    .idx      (idx),
    .src_addr (mem_rd_addr)
  );

  assign spr_addr  = idx;
  assign spr_wdata = mem_rd_data;

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && !bus_grant |=> mem_rd_en && $stable(mem_rd_addr));

  // R6
  retrig_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && trig_wr |=> $stable(page_q));

  // R5
  dead_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && trig_wr && !region_copyable(trig_page[PAGE_W-1 -: SEL_BITS])
    |=> !busy);

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && mem_rd_en && (spr_addr == '0));
endmodule

// File: tb/spr_page_dma_bench.sv
module spr_page_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_wr = 1'b0;
  logic [7:0]  trig_page = 8'h00;
  logic        bus_grant = 1'b1;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = 8'h00;
  logic        spr_we;
  logic [7:0]  spr_addr;
  logic [7:0]  spr_wdata;
  logic        busy;
  logic        done;

  always #4 clk = ~clk;

  spr_page_dma u_spr_page_dma (
    .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .trig_page(trig_page),
    .bus_grant(bus_grant), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .spr_we(spr_we), .spr_addr(spr_addr),
    .spr_wdata(spr_wdata), .busy(busy), .done(done)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  function automatic logic [7:0] pat(input logic [15:0] a);
    logic [7:0] h;
    h = a[15:8] * 8'd29;
    return a[7:0] ^ h ^ 8'hA5;
  endfunction

  function automatic logic [15:0] exp_addr(input logic [7:0] p, input int i);
    int base;
    if (p[7:5] == 3'd0) base = (int'(p) * 256) & 32'h07FF;
    else base = int'(p[7:5]) * 32'h2000 + ((int'(p) * 256) & 32'h1FFF);
    return 16'(base + i);
  endfunction

  // memory model: registered read
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en && bus_grant) mem_rd_data <= pat(mem_rd_addr);
    else mem_rd_data <= 8'h3C;
  end

  logic stall_mode = 1'b0;
  always @(posedge clk) bus_grant <= stall_mode ? ((cyc % 3) != 0) : 1'b1;

  // monitor
  logic [7:0] cur_page = 8'h00;
  logic [7:0] spr_model [256];
  int rd_cnt = 0, addr_err = 0, wr_cnt = 0, order_err = 0;
  int busy_cyc = 0, stall_cyc = 0, done_cnt = 0, done_err = 0;
  logic prev_busy = 1'b0, prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_en && bus_grant) begin
        if (mem_rd_addr != exp_addr(cur_page, rd_cnt)) addr_err++;
        rd_cnt++;
      end
      if (mem_rd_en && !bus_grant) stall_cyc++;
      if (spr_we) begin
        if (int'(spr_addr) != wr_cnt) order_err++;
        spr_model[spr_addr] = spr_wdata;
        wr_cnt++;
      end
      if (busy) busy_cyc++;
      if (done) begin
        done_cnt++;
        if (busy || !prev_busy || prev_done) done_err++;
      end
      prev_busy = busy;
      prev_done = done;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    rd_cnt = 0; addr_err = 0; wr_cnt = 0; order_err = 0;
    busy_cyc = 0; stall_cyc = 0; done_cnt = 0; done_err = 0;
  endtask

  task automatic run_page(input logic [7:0] p, input logic stall, input logic retrig);
    int data_err;
    clear_counts();
    cur_page = p;
    for (int i = 0; i < 256; i++) spr_model[i] = ~pat(exp_addr(p, i));
    stall_mode = stall;
    @(negedge clk);
    trig_wr = 1'b1; trig_page = p;
    @(negedge clk);
    trig_wr = 1'b0;
    if (p[7:5] == 3'd1 || p[7:5] == 3'd2) begin
      repeat (20) @(negedge clk);
      // R5: dead region does nothing
      check("R5 reads", rd_cnt, 0);
      check("R5 busy", busy_cyc, 0);
      check("R5 done", done_cnt, 0);
      return;
    end
    if (retrig) begin
      repeat (250) @(negedge clk);
      trig_wr = 1'b1; trig_page = p ^ 8'h9B;
      @(negedge clk);
      trig_wr = 1'b0;
    end
    for (int w = 0; w < 3000 && done_cnt == 0; w++) @(negedge clk);
    repeat (2) @(negedge clk);
    data_err = 0;
    for (int i = 0; i < 256; i++)
      if (spr_model[i] != pat(exp_addr(p, i))) data_err++;
    // R1: 256 bytes, busy span
    check("R1 reads", rd_cnt, 256);
    check("R1 busy span", busy_cyc, 512 + stall_cyc);
    // R2: source addresses
    check("R2 addr", addr_err, 0);
    // R3: order and data
    check("R3 order", order_err, 0);
    check("R3 data", data_err, 0);
    // R4 / R7
    check("R4 writes", wr_cnt, 256);
    check("R7 done", done_cnt, 1);
    check("R7 done timing", done_err, 0);
    if (stall) check("R4 stalls seen", int'(stall_cyc > 0), 1);
    if (retrig) check("R6 retrigger ignored", addr_err + data_err, 0);
    stall_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 busy", int'(busy), 0);
    check("R8 done", int'(done), 0);
    check("R8 rd_en", int'(mem_rd_en), 0);
    check("R8 spr_we", int'(spr_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", int'(busy | done | mem_rd_en | spr_we), 0);
    for (int p = 0; p < 256; p++) begin
      run_page(8'(p), (p % 37) == 5, (p % 41) == 7);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule